// File: doc/BRIEF.md
# SPR Access Gate

This block sits between a 32-bit core's move-to-SPR and move-from-SPR instructions and the special-purpose register storage. Each request carries a direction, a 16-bit register address and, for writes, a data word. The gate first checks privilege using two status bits: the supervisor flag and the flag that lets user code reach special registers. It then checks the address against separate read and write allow lists. A granted request becomes a one-hot read select or a one-hot write enable towards the external register file. A refused request raises an access-error flag instead.

Two addresses have side effects and are never stored. A granted write to the next-PC register starts a one-cycle redirect to the written value. The same pulse tells the core to drop any pending delay-slot state. A write to the tick-timer mode register is accepted only when the data is zero, and then has no effect at all. The gate also contains a small register file: the 512-entry shadow copy of the general-purpose registers, which is written and read back directly through the gate.

The address is split into a 5-bit group (bits 15:11) and an 11-bit index (bits 10:0). Reads are combinational. Writes and the redirect take effect at the clock edge on which the request is valid.

The redirect sequencer is a two-state machine:
- ST_IDLE leaves `redir_o` low.
- ST_REDIR drives `redir_o` high.
- Transition "launch" (ST_IDLE to ST_REDIR) is taken on a granted next-PC write.
- Transition "rearm" (ST_REDIR to ST_REDIR) is taken on a further granted next-PC write.
- Transition "retire" (ST_REDIR to ST_IDLE) is taken on any other cycle.

Top module: `spr_gate`

## Requirements
- R1: A valid request made while both `sr_super_i` and `sr_usr_spr_i` are low is refused. `err_o` is high, and no read select, write enable, window write or redirect results.
- R2: Any read that raises `err_o` returns `rd_data_o` = 0 with `rd_sel_o` = 0. With `req_valid_i` low, `err_o`, `rd_sel_o` and `wr_en_o` are all 0.
- R3: A granted read to one of the named registers below drives exactly one `rd_sel_o` bit and passes `ext_rdata_i` to `rd_data_o`. The readable registers, as address -> bit, are:
  - 0x0000->0, 0x0001->1, 0x0002->2 (version, unit-present, configuration)
  - 0x0011->3 (status), 0x0012->4 (previous PC)
  - 0x0014->5 (FPU control/status), 0x0020->6 (exception PC)
  - 0x2801->8 (MAC low), 0x2802->9 (MAC high)
- R4: A granted write drives exactly one `wr_en_o` bit, with `wr_data_o` = `req_wdata_i`, for the six writable addresses (address -> bit): 0x0011->3, 0x0014->5, 0x0020->6, 0x0040->7 (saved status), 0x2801->8, 0x2802->9. Address 0x0040 is not readable, so a read of it raises `err_o`.
- R5: Addresses in group 0 with index 1024..1535 form the shadow window. A granted write stores the data in entry index-1024, and a granted read returns that entry without raising `err_o`.
- R6: A granted write to 0x0010 (next PC) stores nothing and raises no enable. In the following cycle `redir_o` is high and `redir_pc_o` holds the written value; this pulse also commands a delay-slot clear. `redir_o` is high in a cycle exactly when the previous cycle held a granted next-PC write, so back-to-back writes keep it high.
- R7: A granted write to 0x5000 (tick-timer mode) with zero data raises neither `err_o` nor any enable or redirect. With nonzero data it raises `err_o`. A read of 0x5000 raises `err_o`.
- R8: Every other address raises `err_o` on a granted read or write, including the next-PC address on a read.
- R9: After reset, `redir_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_addr_i | input | 16 | SPR address: group in 15:11, index in 10:0 |
| req_wdata_i | input | 32 | Write data |
| sr_super_i | input | 1 | Status register supervisor flag |
| sr_usr_spr_i | input | 1 | Status register flag allowing user access to SPRs |
| ext_rdata_i | input | 32 | Read data from the external register file for the selected register |
| rd_data_o | output | 32 | Read result, zero when refused |
| rd_sel_o | output | 10 | One-hot read select for named registers |
| wr_en_o | output | 10 | One-hot write enable for named registers |
| wr_data_o | output | 32 | Write data towards the register file |
| err_o | output | 1 | Access error for the current request |
| redir_o | output | 1 | PC redirect and delay-slot clear pulse |
| redir_pc_o | output | 32 | Redirect target |

## Verification
The two pieces of state inside the gate show up at the ports in different ways.

If the redirect sequencer is in the wrong state, `redir_o` shows it in the very next cycle: a missing pulse, a stale pulse, or a pulse that lasts too long. Each of these is visible one cycle after the write that should or should not have launched it.

If the shadow window is corrupted, nothing shows until that entry is next read. The sweep therefore writes every window entry first and then reads every entry back, so a bad write index or a dropped write appears as a wrong `rd_data_o` during the read pass.

// File: rtl/spr_gate_pkg.sv
package spr_gate_pkg;
    localparam int GRP_W   = 5;
    localparam int IDX_W   = 11;
    localparam int ADDR_W  = GRP_W + IDX_W;
    localparam int NAMED_N = 10;
    localparam int WIN_BASE = 1024;

    typedef enum logic [3:0] {
        TG_VER   = 4'd0,
        TG_UNIT  = 4'd1,
        TG_CFG   = 4'd2,
        TG_STAT  = 4'd3,
        TG_PREV  = 4'd4,
        TG_FPCS  = 4'd5,
        TG_EPC   = 4'd6,
        TG_ESTAT = 4'd7,
        TG_MLO   = 4'd8,
        TG_MHI   = 4'd9,
        TG_NEXT  = 4'd10,
        TG_TMODE = 4'd11,
        TG_WIN   = 4'd12,
        TG_NONE  = 4'd13
    } spr_tgt_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REDIR = 1'b1
    } redir_st_e;

    localparam logic [ADDR_W-1:0] A_VER   = 16'h0000;
    localparam logic [ADDR_W-1:0] A_UNIT  = 16'h0001;
    localparam logic [ADDR_W-1:0] A_CFG   = 16'h0002;
    localparam logic [ADDR_W-1:0] A_NEXT  = 16'h0010;
    localparam logic [ADDR_W-1:0] A_STAT  = 16'h0011;
    localparam logic [ADDR_W-1:0] A_PREV  = 16'h0012;
    localparam logic [ADDR_W-1:0] A_FPCS  = 16'h0014;
    localparam logic [ADDR_W-1:0] A_EPC   = 16'h0020;
    localparam logic [ADDR_W-1:0] A_ESTAT = 16'h0040;
    localparam logic [ADDR_W-1:0] A_MLO   = 16'h2801;
    localparam logic [ADDR_W-1:0] A_MHI   = 16'h2802;
    localparam logic [ADDR_W-1:0] A_TMODE = 16'h5000;

    // bit n set: named target n may be read / written
    localparam logic [NAMED_N-1:0] RD_OK_MASK = 10'b11_0111_1111;
    localparam logic [NAMED_N-1:0] WR_OK_MASK = 10'b11_1110_1000;
endpackage

// File: rtl/spr_addr_decode.sv
module spr_addr_decode
    import spr_gate_pkg::*;
#(
    parameter int WIN_DEPTH = 512,
    localparam int WIN_AW = $clog2(WIN_DEPTH)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output spr_tgt_e          tgt_o,
    output logic [WIN_AW-1:0] win_idx_o
);
    logic [GRP_W-1:0] grp;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] off;
    logic             win_hit;

    assign grp = addr_i[ADDR_W-1:IDX_W];
    assign idx = addr_i[IDX_W-1:0];
    assign off = idx - IDX_W'(WIN_BASE);
    assign win_hit = (grp == '0) && (idx >= IDX_W'(WIN_BASE)) && (off < IDX_W'(WIN_DEPTH));
    assign win_idx_o = off[WIN_AW-1:0];

    always_comb begin
        case (addr_i)
            A_VER:   tgt_o = TG_VER;
            A_UNIT:  tgt_o = TG_UNIT;
            A_CFG:   tgt_o = TG_CFG;
            A_NEXT:  tgt_o = TG_NEXT;
            A_STAT:  tgt_o = TG_STAT;
            A_PREV:  tgt_o = TG_PREV;
            A_FPCS:  tgt_o = TG_FPCS;
            A_EPC:   tgt_o = TG_EPC;
            A_ESTAT: tgt_o = TG_ESTAT;
            A_MLO:   tgt_o = TG_MLO;
            A_MHI:   tgt_o = TG_MHI;
            A_TMODE: tgt_o = TG_TMODE;
            default: tgt_o = win_hit ? TG_WIN : TG_NONE;
        endcase
    end
endmodule

// File: rtl/spr_shadow_window.sv
module spr_shadow_window #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[idx_i];
endmodule

// File: rtl/spr_redirect_fsm.sv
module spr_redirect_fsm
    import spr_gate_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic [DW-1:0] pc_i,
    output logic          redir_o,
    output logic [DW-1:0] pc_o
);
    redir_st_e state, state_nxt;
    logic [DW-1:0] pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc_q  <= '0;
        end else begin
            state <= state_nxt;
            if (fire_i) begin
                pc_q <= pc_i;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  state_nxt = fire_i ? ST_REDIR : ST_IDLE;   // launch
            ST_REDIR: state_nxt = fire_i ? ST_REDIR : ST_IDLE;   // rearm / retire
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        redir_o = (state == ST_REDIR);
        pc_o    = pc_q;
    end
endmodule

// File: rtl/spr_gate.sv
module spr_gate
    import spr_gate_pkg::*;
#(
    parameter int DW        = 32,
    parameter int WIN_DEPTH = 512,
    localparam int WIN_AW   = $clog2(WIN_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic [DW-1:0]      req_wdata_i,
    input  logic               sr_super_i,
    input  logic               sr_usr_spr_i,
    input  logic [DW-1:0]      ext_rdata_i,
    output logic [DW-1:0]      rd_data_o,
    output logic [NAMED_N-1:0] rd_sel_o,
    output logic [NAMED_N-1:0] wr_en_o,
    output logic [DW-1:0]      wr_data_o,
    output logic               err_o,
    output logic               redir_o,
    output logic [DW-1:0]      redir_pc_o
);
    spr_tgt_e          tgt;
    logic [WIN_AW-1:0] win_idx;
    logic [DW-1:0]     win_rdata;
    logic              win_we;
    logic              npc_fire;
    logic              grant;
    logic              named;

    spr_addr_decode #(.WIN_DEPTH(WIN_DEPTH)) u_dec (
        .addr_i    (req_addr_i),
        .tgt_o     (tgt),
        .win_idx_o (win_idx)
    );

    spr_shadow_window #(.DEPTH(WIN_DEPTH), .DW(DW)) u_win (
        .clk     (clk),
        .we_i    (win_we),
        .idx_i   (win_idx),
        .wdata_i (req_wdata_i),
        .rdata_o (win_rdata)
    );

    spr_redirect_fsm #(.DW(DW)) u_redir (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (npc_fire),
        .pc_i    (req_wdata_i),
        .redir_o (redir_o),
        .pc_o    (redir_pc_o)
    );

    assign grant     = sr_super_i | sr_usr_spr_i;
    assign named     = (tgt <= TG_MHI);
    assign wr_data_o = req_wdata_i;

    always_comb begin
        rd_sel_o  = '0;
        wr_en_o   = '0;
        rd_data_o = '0;
        err_o     = 1'b0;
        win_we    = 1'b0;
        npc_fire  = 1'b0;
        if (req_valid_i) begin
            if (!grant) begin
                err_o = 1'b1;
            end else if (!req_write_i) begin
                if (tgt == TG_WIN) begin
                    rd_data_o = win_rdata;
                end else if (named && RD_OK_MASK[tgt]) begin
                    rd_sel_o[tgt] = 1'b1;
                    rd_data_o     = ext_rdata_i;
                end else begin
                    err_o = 1'b1;
                end
            end else begin
                if (tgt == TG_WIN) begin
                    win_we = 1'b1;
                end else if (tgt == TG_NEXT) begin
                    npc_fire = 1'b1;
                end else if (tgt == TG_TMODE) begin
                    err_o = (req_wdata_i != '0);
                end else if (named && WR_OK_MASK[tgt]) begin
                    wr_en_o[tgt] = 1'b1;
                end else begin
                    err_o = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spr_gate_chk.sv
module spr_gate_chk
    import spr_gate_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid_i,
    input logic               req_write_i,
    input logic [ADDR_W-1:0]  req_addr_i,
    input logic [31:0]        req_wdata_i,
    input logic               sr_super_i,
    input logic               sr_usr_spr_i,
    input logic [31:0]        rd_data_o,
    input logic [NAMED_N-1:0] rd_sel_o,
    input logic [NAMED_N-1:0] wr_en_o,
    input logic               err_o,
    input logic               redir_o,
    input logic [31:0]        redir_pc_o
);
    logic npc_wr;
    assign npc_wr = req_valid_i && req_write_i && (sr_super_i || sr_usr_spr_i)
                    && (req_addr_i == A_NEXT);

    // R1
    unpriv_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !sr_super_i && !sr_usr_spr_i) |-> (err_o && wr_en_o == '0 && rd_sel_o == '0));

    // R2
    refused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i && err_o) |-> (rd_data_o == '0));

    // R3
    rd_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel_o) && (rd_sel_o == '0 || (!err_o && !req_write_i)));

    // R4
    wr_en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_o) && (wr_en_o == '0 || (!err_o && req_write_i && req_valid_i)));

    // R6
    redir_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        npc_wr |=> (redir_o && redir_pc_o == $past(req_wdata_i)));

    // R6
    redir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !npc_wr |=> !redir_o);

    // R7
    tmode_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && (sr_super_i || sr_usr_spr_i)
         && req_addr_i == A_TMODE && req_wdata_i != '0) |-> err_o);
endmodule

bind spr_gate spr_gate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .sr_super_i   (sr_super_i),
    .sr_usr_spr_i (sr_usr_spr_i),
    .rd_data_o    (rd_data_o),
    .rd_sel_o     (rd_sel_o),
    .wr_en_o      (wr_en_o),
    .err_o        (err_o),
    .redir_o      (redir_o),
    .redir_pc_o   (redir_pc_o)
);

// File: tb/sim_spr_gate.sv
module sim_spr_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [15:0] req_addr_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic        sr_super_i = 1'b0;
    logic        sr_usr_spr_i = 1'b0;
    logic [31:0] ext_rdata_i = '0;
    logic [31:0] rd_data_o;
    logic [9:0]  rd_sel_o;
    logic [9:0]  wr_en_o;
    logic [31:0] wr_data_o;
    logic        err_o;
    logic        redir_o;
    logic [31:0] redir_pc_o;

    int total = 0;
    int fails = 0;
    logic [31:0] exp_mem [512];

    always #2 clk = ~clk;

    spr_gate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .sr_super_i(sr_super_i),
        .sr_usr_spr_i(sr_usr_spr_i), .ext_rdata_i(ext_rdata_i), .rd_data_o(rd_data_o),
        .rd_sel_o(rd_sel_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .err_o(err_o),
        .redir_o(redir_o), .redir_pc_o(redir_pc_o)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int named_of(logic [15:0] a);
        case (a)
            16'h0000: return 0;
            16'h0001: return 1;
            16'h0002: return 2;
            16'h0011: return 3;
            16'h0012: return 4;
            16'h0014: return 5;
            16'h0020: return 6;
            16'h0040: return 7;
            16'h2801: return 8;
            16'h2802: return 9;
            default:  return -1;
        endcase
    endfunction

    function automatic bit in_win(logic [15:0] a);
        return (a[15:11] == 5'd0) && (a[10:0] >= 11'd1024) && (a[10:0] < 11'd1536);
    endfunction

    function automatic logic [31:0] pat(logic [15:0] a);
        return {~a, a};
    endfunction

    task automatic access(bit wr, logic [15:0] a, logic [31:0] d, bit sm, bit su);
        bit grant;
        int n;
        bit e_err;
        bit e_fire;
        bit e_store;
        logic [9:0]  e_wr;
        logic [9:0]  e_rs;
        logic [31:0] e_rd;
        @(negedge clk);
        req_valid_i  = 1'b1;
        req_write_i  = wr;
        req_addr_i   = a;
        req_wdata_i  = d;
        sr_super_i   = sm;
        sr_usr_spr_i = su;
        ext_rdata_i  = {16'hC0DE, a};
        #1;
        grant = sm | su;
        n = named_of(a);
        e_err = 1'b0; e_fire = 1'b0; e_store = 1'b0;
        e_wr = '0; e_rs = '0; e_rd = '0;
        if (!grant) e_err = 1'b1;                           // R1
        else if (!wr) begin
            if (in_win(a)) e_rd = exp_mem[a[10:0] - 11'd1024];  // R5
            else if (n >= 0 && n != 7) begin e_rs[n] = 1'b1; e_rd = {16'hC0DE, a}; end // R3
            else e_err = 1'b1;                              // R2 R7 R8
        end else begin
            if (in_win(a)) e_store = 1'b1;                  // R5
            else if (a == 16'h0010) e_fire = 1'b1;          // R6
            else if (a == 16'h5000) e_err = (d != 0);       // R7
            else if (n == 3 || n >= 5) e_wr[n] = 1'b1;      // R4
            else e_err = 1'b1;                              // R8
        end
        chk(err_o == e_err, "R1/R8 err", 32'(err_o), 32'(e_err));
        if (wr) begin
            chk(wr_en_o == e_wr, "R4 wr_en", 32'(wr_en_o), 32'(e_wr));
            if (e_wr != 0) chk(wr_data_o == d, "R4 wr_data", wr_data_o, d);
        end else begin
            chk(rd_data_o == e_rd, "R2/R3/R5 rd_data", rd_data_o, e_rd);
            chk(rd_sel_o == e_rs, "R3 rd_sel", 32'(rd_sel_o), 32'(e_rs));
        end
        @(posedge clk);
        if (e_store) exp_mem[a[10:0] - 11'd1024] = d;
        #1;
        chk(redir_o == e_fire, "R6 redir", 32'(redir_o), 32'(e_fire));
        if (e_fire) chk(redir_pc_o == d, "R6 redir_pc", redir_pc_o, d);
    endtask

    task automatic sweep(bit wr);
        for (int i = 0; i < 2048; i++) begin
            for (int p = 0; p < 4; p++) access(wr, 16'(i), pat(16'(i)), p[1], p[0]);
        end
        for (int i = 0; i < 8; i++) begin
            for (int p = 0; p < 4; p++) access(wr, 16'h2800 | 16'(i), pat(16'h2800 | 16'(i)), p[1], p[0]);
        end
        for (int g = 1; g < 32; g++) begin
            access(wr, {5'(g), 11'h000}, pat({5'(g), 11'h000}), 1'b1, 1'b0);
            access(wr, {5'(g), 11'h011}, pat({5'(g), 11'h011}), 1'b0, 1'b1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int k = 0; k < 512; k++) exp_mem[k] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(redir_o == 1'b0, "R9 reset redir", 32'(redir_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(redir_o == 1'b0, "R9 idle redir", 32'(redir_o), 32'd0);
        chk(err_o == 1'b0 && rd_sel_o == 0 && wr_en_o == 0, "R2 idle outputs",
            {20'd0, err_o, rd_sel_o, wr_en_o[0]}, 32'd0);
        // R7 directed: zero accepted silently, nonzero refused, unprivileged refused
        access(1'b1, 16'h5000, 32'd0, 1'b1, 1'b0);
        access(1'b1, 16'h5000, 32'd0, 1'b0, 1'b1);
        access(1'b1, 16'h5000, 32'd5, 1'b1, 1'b0);
        access(1'b1, 16'h5000, 32'd0, 1'b0, 1'b0);
        // R6 directed: back-to-back redirects then retire
        access(1'b1, 16'h0010, 32'h0000_1000, 1'b1, 1'b0);
        access(1'b1, 16'h0010, 32'h0000_2000, 1'b1, 1'b1);
        access(1'b0, 16'h0010, 32'h0000_3000, 1'b1, 1'b0);
        sweep(1'b1);
        sweep(1'b0);
        req_valid_i = 1'b0;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule